// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Framer

This block is a stereo audio serial port for 16-bit left and right samples. One sequencer covers I2S, left-justified, right-justified, DSP-A and DSP-B framing. Each framing is picked by a two-bit mode field together with a separate one-bit data offset. The bit clock and the frame clock can each be generated locally (master) or taken from the pins (slave), and each has its own polarity inversion. The half-frame length is programmable. All timing is carried by one system clock: in master mode a half-bit-period strobe paces the bit clock, and in slave mode the pin clocks are synchronised and edge-detected.

The transmit side takes one stereo sample pair per frame through a ready/valid handshake and shifts it out MSB first. The receive side samples the serial input on the other bit-clock edge and presents the assembled pair with a one-cycle valid pulse.

The sequencer has three states. OFF is entered on reset and whenever `en` is low; in OFF the bit position is held at the last position of the frame. WAIT is entered from OFF when `en` rises and the frame clock is slave; it leaves for RUN on the first frame-start edge of the frame clock. RUN is entered directly from OFF when the frame clock is master, or from WAIT on the frame-start edge. In RUN the position advances on every shift event; in slave framing it is realigned on frame-clock edges. RUN returns to OFF when `en` drops.

Top module: `afr_framer`

## Requirements
- R1: `mode` selects the framing: 0 = PCM/DSP, 1 = left-justified, 2 = right-justified, 3 = reserved (no data bits, serial output stays 0). In left-justified mode with `data_off`=0, bit 15 of a slot goes out on the first bit clock of its half frame, the left slot in the first half and the right slot in the second half.
- R2: Left-justified mode with `data_off`=1 is I2S: each slot starts one bit clock after the start of its half frame.
- R3: In right-justified mode the 16 data bits fill the last 16 bit clocks of each half frame, earlier positions carry 0, and `data_off` has no effect.
- R4: In PCM mode the left slot then the right slot go out back to back from frame position `data_off` (0 = DSP-B, 1 = DSP-A); the master frame clock is a one-bit-clock high pulse at position 0, and the bits after the 32 data bits carry 0.
- R5: A half frame lasts `per`+1 bit clocks (`per`=31 gives 32); in the two justified modes the master frame clock is low in the left half and high in the right half.
- R6: `bclk_inv` inverts the bit clock and `lrck_inv` inverts the frame clock, both on the pins and as seen by the slave logic. The uninverted bit clock idles high, and with `en` low the frame clock sits at its level for the right half.
- R7: `bclk_master` and `lrck_master` independently choose whether each clock is generated (and its output enable is set while `en` is high) or taken from the pin through a two-flop synchroniser and edge detector. The serial input is synchronised the same way. A slave port framed by external clocks receives data correctly.
- R8: Data changes after the falling edge of the uninverted bit clock and is sampled on the rising edge. Samples are sent MSB first. `tx_ready` is a one-cycle pulse at each frame start while `tx_en` is high, and the pair is taken when `tx_valid` is high in that cycle.
- R9: If `tx_valid` is low at a frame start, the whole frame carries zeros and `tx_underrun` pulses for one cycle.
- R10: `sdo_oe` is high only while `en`, `tx_en` and `sdo_en` are all high; `sdo` is 0 whenever `sdo_oe` is low.
- R11: After the last bit of a frame is sampled, `rx_valid` pulses for one cycle with the received pair on `rx_left` and `rx_right`; while `rx_en` is low, no pulse appears.
- R12: After reset, with `en` low, `bclk_o` is 1 and `sdo`, `sdo_oe`, `rx_valid`, `tx_ready` and `tx_underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Port enable |
| mode | input | 2 | Framing select (0 PCM, 1 LJ, 2 RJ) |
| data_off | input | 1 | Data offset of one bit clock |
| per | input | PER_W | Half-frame length minus one |
| bclk_inv | input | 1 | Bit-clock polarity inversion |
| lrck_inv | input | 1 | Frame-clock polarity inversion |
| bclk_master | input | 1 | Generate the bit clock |
| lrck_master | input | 1 | Generate the frame clock |
| sdo_en | input | 1 | Serial data output enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| half_stb | input | 1 | Half-bit-period strobe for master bit clock |
| bclk_i | input | 1 | Bit clock from pin (slave) |
| lrck_i | input | 1 | Frame clock from pin (slave) |
| sdi | input | 1 | Serial data in |
| bclk_o | output | 1 | Bit clock to pin |
| bclk_oe | output | 1 | Bit clock output enable |
| lrck_o | output | 1 | Frame clock to pin |
| lrck_oe | output | 1 | Frame clock output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| tx_valid | input | 1 | Transmit pair valid |
| tx_left | input | 16 | Transmit left sample |
| tx_right | input | 16 | Transmit right sample |
| tx_ready | output | 1 | Transmit pair accepted at frame start |
| tx_underrun | output | 1 | No pair at frame start |
| rx_valid | output | 1 | Received pair valid |
| rx_left | output | 16 | Received left sample |
| rx_right | output | 16 | Received right sample |

## Verification
A frame start and the sampling of the last frame bit both happen around the frame wrap. With the serial output looped back to the input, the transmit load (with or without an underrun) and the receive completion fall within a bit clock of each other. The bench holds `tx_valid` low across a frame start while receiving, and then checks both the underrun pulse and the all-zero pair that was received. In every framing mode the received pair, and the serial frame read independently at the bit-clock rising edges, must match the pair that was loaded at the same wrap.

// File: rtl/afr_pkg.sv
package afr_pkg;
    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        FMT_PCM = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } seq_st_e;
endpackage

// File: rtl/afr_sync.sv
module afr_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/afr_slot_map.sv
module afr_slot_map
    import afr_pkg::*;
#(
    parameter int PW = 9
) (
    input  fmt_e          fmt,
    input  logic          off,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] half,
    output logic          hit,
    output logic          slot,
    output logic [3:0]    idx
);
    logic          second;
    logic [PW-1:0] h;
    logic [PW-1:0] d;
    logic [PW-1:0] offw;

    always_comb begin
        offw   = {{(PW-1){1'b0}}, off};
        second = (pos >= half);
        h      = second ? pos - half : pos;
        d      = '0;
        hit    = 1'b0;
        slot   = 1'b0;
        unique case (fmt)
            FMT_PCM: begin
                d    = pos - offw;
                hit  = (pos >= offw) && (d < PW'(32));
                slot = d[4];
            end
            FMT_LJ: begin
                d    = h - offw;
                hit  = (h >= offw) && (d < PW'(16));
                slot = second;
            end
            FMT_RJ: begin
                d    = h - (half - PW'(16));
                hit  = (h >= half - PW'(16));
                slot = second;
            end
            default: begin
                d   = '0;
                hit = 1'b0;
            end
        endcase
        idx = d[3:0];
    end
endmodule

// File: rtl/afr_clk_events.sv
module afr_clk_events (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic bclk_master,
    input  logic bclk_inv,
    input  logic lrck_inv,
    input  logic half_stb,
    input  logic bclk_s,
    input  logic lrck_s,
    output logic shift_ev,
    output logic samp_ev,
    output logic lr_lvl,
    output logic bclk_o
);
    logic bclk_int;
    logic bclk_d;
    logic eb_now;
    logic eb_old;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_int <= 1'b1;
            bclk_d   <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            if (!en)
                bclk_int <= 1'b1;
            else if (half_stb)
                bclk_int <= ~bclk_int;
        end
    end

    always_comb begin
        eb_now   = bclk_s ^ bclk_inv;
        eb_old   = bclk_d ^ bclk_inv;
        shift_ev = bclk_master ? (en & half_stb & bclk_int)  : (eb_old & ~eb_now);
        samp_ev  = bclk_master ? (en & half_stb & ~bclk_int) : (~eb_old & eb_now);
        lr_lvl   = lrck_s ^ lrck_inv;
        bclk_o   = bclk_int ^ bclk_inv;
    end
endmodule

// File: rtl/afr_seq.sv
module afr_seq
    import afr_pkg::*;
#(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          frame_master,
    input  fmt_e          fmt,
    input  logic [PW-1:0] half,
    input  logic          shift_ev,
    input  logic          lr_in,
    output seq_st_e       state,
    output logic [PW-1:0] pos,
    output logic [PW-1:0] pos_n,
    output logic          adv,
    output logic          frame_start,
    output logic          at_last,
    output logic          lr_mst
);
    seq_st_e       state_n;
    logic          lr_prev;
    logic [PW-1:0] last;
    logic [PW-1:0] wrap;
    logic [PW-1:0] nxt;
    logic          go_edge;

    // next-state process
    always_comb begin
        last    = {half[PW-2:0], 1'b0} - PW'(1);
        wrap    = (pos == last) ? '0 : pos + PW'(1);
        go_edge = (fmt == FMT_PCM) ? (lr_in & ~lr_prev) : (~lr_in & lr_prev);
        if (frame_master)
            nxt = wrap;
        else if (fmt == FMT_PCM)
            nxt = (lr_in & ~lr_prev) ? '0 : wrap;
        else if (lr_in != lr_prev)
            nxt = lr_in ? half : '0;
        else
            nxt = wrap;

        state_n     = state;
        pos_n       = pos;
        adv         = 1'b0;
        frame_start = 1'b0;
        unique case (state)
            ST_OFF: begin
                pos_n = last;
                if (en) state_n = frame_master ? ST_RUN : ST_WAIT;
            end
            ST_WAIT: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (shift_ev && go_edge) begin
                    state_n     = ST_RUN;
                    pos_n       = '0;
                    adv         = 1'b1;
                    frame_start = 1'b1;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_n = ST_OFF;
                end else if (shift_ev) begin
                    pos_n       = nxt;
                    adv         = 1'b1;
                    frame_start = (nxt == '0);
                end
            end
            default: state_n = ST_OFF;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            pos     <= '0;
            lr_prev <= 1'b0;
        end else begin
            state <= state_n;
            pos   <= pos_n;
            if (shift_ev) lr_prev <= lr_in;
        end
    end

    // output process
    always_comb begin
        at_last = (pos == last);
        unique case (fmt)
            FMT_PCM: lr_mst = (pos == '0);
            FMT_LJ,
            FMT_RJ:  lr_mst = (pos >= half);
            default: lr_mst = 1'b0;
        endcase
    end
endmodule

// File: rtl/afr_tx.sv
module afr_tx
    import afr_pkg::*;
#(
    parameter int PW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idle,
    input  logic                tx_en,
    input  logic                adv,
    input  logic                frame_start,
    input  fmt_e                fmt,
    input  logic                off,
    input  logic [PW-1:0]       pos_n,
    input  logic [PW-1:0]       half,
    input  logic                tx_valid,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_ready,
    output logic                tx_underrun,
    output logic                sdo_q
);
    logic [SAMPLE_W-1:0] cur_l, cur_r, src_l, src_r, sel;
    logic                load, hit, slot;
    logic [3:0]          idx;

    afr_slot_map #(.PW(PW)) u_map (
        .fmt(fmt), .off(off), .pos(pos_n), .half(half),
        .hit(hit), .slot(slot), .idx(idx)
    );

    always_comb begin
        load     = frame_start & tx_en;
        tx_ready = load;
        src_l    = load ? (tx_valid ? tx_left  : '0) : cur_l;
        src_r    = load ? (tx_valid ? tx_right : '0) : cur_r;
        sel      = slot ? src_r : src_l;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_l       <= '0;
            cur_r       <= '0;
            sdo_q       <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            tx_underrun <= load & ~tx_valid;
            if (load) begin
                cur_l <= src_l;
                cur_r <= src_r;
            end
            if (idle || !tx_en)
                sdo_q <= 1'b0;
            else if (adv)
                sdo_q <= hit & sel[4'd15 - idx];
        end
    end
endmodule

// File: rtl/afr_rx.sv
module afr_rx
    import afr_pkg::*;
#(
    parameter int PW = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                rx_en,
    input  logic                samp_ev,
    input  logic                at_last,
    input  fmt_e                fmt,
    input  logic                off,
    input  logic [PW-1:0]       pos,
    input  logic [PW-1:0]       half,
    input  logic                sdi_s,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right
);
    logic [SAMPLE_W-1:0] cap_l, cap_r, new_l, new_r;
    logic                hit, slot, take;
    logic [3:0]          idx;

    afr_slot_map #(.PW(PW)) u_map (
        .fmt(fmt), .off(off), .pos(pos), .half(half),
        .hit(hit), .slot(slot), .idx(idx)
    );

    always_comb begin
        take  = samp_ev & run & rx_en;
        new_l = cap_l;
        new_r = cap_r;
        if (hit && !slot) new_l[4'd15 - idx] = sdi_s;
        if (hit &&  slot) new_r[4'd15 - idx] = sdi_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_l    <= '0;
            cap_r    <= '0;
            rx_valid <= 1'b0;
            rx_left  <= '0;
            rx_right <= '0;
        end else begin
            rx_valid <= take & at_last;
            if (take) begin
                cap_l <= new_l;
                cap_r <= new_r;
                if (at_last) begin
                    rx_left  <= new_l;
                    rx_right <= new_r;
                end
            end
        end
    end
endmodule

// File: rtl/afr_framer.sv
module afr_framer
    import afr_pkg::*;
#(
    parameter int PER_W = 8,
    localparam int PW   = PER_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [1:0]          mode,
    input  logic                data_off,
    input  logic [PER_W-1:0]    per,
    input  logic                bclk_inv,
    input  logic                lrck_inv,
    input  logic                bclk_master,
    input  logic                lrck_master,
    input  logic                sdo_en,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                half_stb,
    input  logic                bclk_i,
    input  logic                lrck_i,
    input  logic                sdi,
    output logic                bclk_o,
    output logic                bclk_oe,
    output logic                lrck_o,
    output logic                lrck_oe,
    output logic                sdo,
    output logic                sdo_oe,
    input  logic                tx_valid,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                tx_ready,
    output logic                tx_underrun,
    output logic                rx_valid,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right
);
    fmt_e          fmt;
    seq_st_e       state;
    logic [PW-1:0] half, pos, pos_n;
    logic [2:0]    pins_s;
    logic          shift_ev, samp_ev, lr_lvl, adv, frame_start, at_last, lr_mst, sdo_q;

    assign fmt  = fmt_e'(mode);
    assign half = {1'b0, per} + PW'(1);

    afr_sync #(.N(3)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sdi, lrck_i, bclk_i}), .q(pins_s)
    );

    afr_clk_events u_ev (
        .clk(clk), .rst_n(rst_n), .en(en), .bclk_master(bclk_master),
        .bclk_inv(bclk_inv), .lrck_inv(lrck_inv), .half_stb(half_stb),
        .bclk_s(pins_s[0]), .lrck_s(pins_s[1]),
        .shift_ev(shift_ev), .samp_ev(samp_ev), .lr_lvl(lr_lvl), .bclk_o(bclk_o)
    );

    afr_seq #(.PW(PW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_master(lrck_master),
        .fmt(fmt), .half(half), .shift_ev(shift_ev), .lr_in(lr_lvl),
        .state(state), .pos(pos), .pos_n(pos_n), .adv(adv),
        .frame_start(frame_start), .at_last(at_last), .lr_mst(lr_mst)
    );

    afr_tx #(.PW(PW)) u_tx (
        .clk(clk), .rst_n(rst_n), .idle(state == ST_OFF), .tx_en(tx_en),
        .adv(adv), .frame_start(frame_start), .fmt(fmt), .off(data_off),
        .pos_n(pos_n), .half(half), .tx_valid(tx_valid), .tx_left(tx_left),
        .tx_right(tx_right), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
        .sdo_q(sdo_q)
    );

    afr_rx #(.PW(PW)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(state == ST_RUN), .rx_en(rx_en),
        .samp_ev(samp_ev), .at_last(at_last), .fmt(fmt), .off(data_off),
        .pos(pos), .half(half), .sdi_s(pins_s[2]), .rx_valid(rx_valid),
        .rx_left(rx_left), .rx_right(rx_right)
    );

    assign lrck_o  = lr_mst ^ lrck_inv;
    assign bclk_oe = en & bclk_master;
    assign lrck_oe = en & lrck_master;
    assign sdo_oe  = en & tx_en & sdo_en;
    assign sdo     = sdo_q & sdo_oe;
endmodule

// File: rtl/afr_framer_chk.sv
module afr_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic half_stb,
    input logic bclk_master,
    input logic bclk_inv,
    input logic bclk_o,
    input logic tx_valid,
    input logic tx_ready,
    input logic tx_underrun,
    input logic rx_en,
    input logic rx_valid
);
    // R9: an underrun follows a frame start that had no pair
    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(tx_ready && !tx_valid));

    // R8: the accept strobe lasts one cycle
    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    // R11: receive valid lasts one cycle
    p_rx_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11: no receive valid unless the receiver was enabled
    p_rx_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rx_en));

    // R7: a generated bit clock moves only on the half-period strobe
    p_bclk_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk_master && en && $past(en) && $stable(bclk_inv) && !$stable(bclk_o))
            |-> $past(half_stb));
endmodule

bind afr_framer afr_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .half_stb(half_stb),
    .bclk_master(bclk_master), .bclk_inv(bclk_inv), .bclk_o(bclk_o),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
    .rx_en(rx_en), .rx_valid(rx_valid)
);

// File: tb/afr_framer_test.sv
module afr_framer_test;
    localparam int H = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, en, data_off, bclk_inv, lrck_inv, bclk_master, lrck_master;
    logic        sdo_en, tx_en, rx_en, half_stb, bclk_i, lrck_i, sdi, tx_valid;
    logic [1:0]  mode;
    logic [7:0]  per;
    logic [15:0] tx_left, tx_right, rx_left, rx_right;
    logic        bclk_o, bclk_oe, lrck_o, lrck_oe, sdo, sdo_oe;
    logic        tx_ready, tx_underrun, rx_valid;

    assign sdi = sdo;

    afr_framer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .data_off(data_off),
        .per(per), .bclk_inv(bclk_inv), .lrck_inv(lrck_inv),
        .bclk_master(bclk_master), .lrck_master(lrck_master), .sdo_en(sdo_en),
        .tx_en(tx_en), .rx_en(rx_en), .half_stb(half_stb), .bclk_i(bclk_i),
        .lrck_i(lrck_i), .sdi(sdi), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
        .lrck_o(lrck_o), .lrck_oe(lrck_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .tx_valid(tx_valid), .tx_left(tx_left), .tx_right(tx_right),
        .tx_ready(tx_ready), .tx_underrun(tx_underrun), .rx_valid(rx_valid),
        .rx_left(rx_left), .rx_right(rx_right)
    );

    int n_chk = 0;
    int n_fail = 0;
    int rxv_cnt = 0;
    int und_cnt = 0;
    int sdo_hi = 0;
    logic stb_on = 1'b0;
    logic [63:0] fr_cur, fr_done;

    // {mode, offset, left, right}
    localparam logic [34:0] VEC [6] = '{
        {2'd1, 1'b0, 16'hA5C3, 16'h1E0F},
        {2'd1, 1'b1, 16'h8001, 16'h7FFE},
        {2'd2, 1'b0, 16'hF00D, 16'h0BEE},
        {2'd2, 1'b1, 16'h1234, 16'hCDEF},
        {2'd0, 1'b0, 16'h4321, 16'h9ABC},
        {2'd0, 1'b1, 16'hFFFF, 16'h0001}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(input logic [1:0] m, input logic o,
                                              input logic [15:0] l, input logic [15:0] r);
        logic [63:0] f;
        f = '0;
        for (int p = 0; p < 2 * H; p++) begin
            int h, d;
            logic [15:0] s;
            h = (p >= H) ? p - H : p;
            s = (p >= H) ? r : l;
            if (m == 2'd1) begin
                d = h - int'(o);
                if (d >= 0 && d < 16) f[p] = s[15 - d];
            end else if (m == 2'd2) begin
                d = h - (H - 16);
                if (d >= 0) f[p] = s[15 - d];
            end else if (m == 2'd0) begin
                d = p - int'(o);
                if (d >= 0 && d < 16) f[p] = l[15 - d];
                else if (d >= 16 && d < 32) f[p] = r[31 - d];
            end
        end
        return f;
    endfunction

    // half-period strobe: one pulse every 4 clocks
    initial begin
        int div = 0;
        half_stb = 1'b0;
        forever begin
            @(negedge clk);
            half_stb = stb_on && (div == 3);
            div = (div + 1) % 4;
        end
    end

    // independent frame reader at bit-clock rising edges (uninverted, master)
    initial begin
        logic pb = 1'b1;
        logic plr = 1'b1;
        int bp = 0;
        forever begin
            @(negedge clk);
            if (rx_valid) rxv_cnt++;
            if (tx_underrun) und_cnt++;
            if (sdo) sdo_hi++;
            if (!pb && bclk_o) begin
                if (mode == 2'd0) bp = lrck_o ? 0 : bp + 1;
                else bp = (!lrck_o && plr) ? 0 : bp + 1;
                plr = lrck_o;
                if (bp < 64) fr_cur[bp] = sdo;
                if (bp == 2 * H - 1) fr_done = fr_cur;
            end
            pb = bclk_o;
        end
    end

    task automatic wait_rx(input int n);
        int s;
        s = rxv_cnt;
        while (rxv_cnt < s + n) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; mode = 2'd1; data_off = 1'b0; per = 8'd31;
        bclk_inv = 1'b0; lrck_inv = 1'b0; bclk_master = 1'b1; lrck_master = 1'b1;
        sdo_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1; bclk_i = 1'b1; lrck_i = 1'b1;
        tx_valid = 1'b0; tx_left = '0; tx_right = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R12 reset state
        chk("R12 idle outputs", {58'd0, bclk_o, sdo, sdo_oe, rx_valid, tx_ready, tx_underrun},
            {58'd0, 1'b1, 5'b0});

        stb_on = 1'b1;
        // table walk: loopback in each framing
        for (int i = 0; i < 6; i++) begin
            en = 1'b0;
            repeat (4) @(negedge clk);
            {mode, data_off, tx_left, tx_right} = VEC[i];
            tx_valid = 1'b1;
            en = 1'b1;
            wait_rx(3);
            chk($sformatf("R8 R11 rx pair vec%0d", i), {32'd0, rx_left, rx_right},
                {32'd0, VEC[i][31:16], VEC[i][15:0]});
            chk($sformatf("R1 R2 R3 R4 serial frame vec%0d", i), fr_done,
                exp_frame(VEC[i][34:33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]));
        end

        // R9 underrun: no pair offered
        en = 1'b0;
        repeat (4) @(negedge clk);
        mode = 2'd1; data_off = 1'b1; tx_valid = 1'b0; und_cnt = 0;
        en = 1'b1;
        wait_rx(3);
        chk("R9 underrun flagged", {63'd0, und_cnt > 0}, 64'd1);
        chk("R9 zero frame received", {32'd0, rx_left, rx_right}, 64'd0);

        // R11 receiver disabled
        rx_en = 1'b0; tx_valid = 1'b1;
        begin
            int s;
            s = rxv_cnt;
            repeat (1200) @(negedge clk);
            chk("R11 no valid while rx disabled", 64'(rxv_cnt - s), 64'd0);
        end
        rx_en = 1'b1;

        // R10 / R7 output enables
        sdo_en = 1'b0; tx_left = 16'hFFFF; tx_right = 16'hFFFF;
        sdo_hi = 0;
        repeat (600) @(negedge clk);
        chk("R10 sdo gated", {62'd0, sdo_oe, 1'b0}, 64'd0);
        chk("R10 sdo held low", 64'(sdo_hi), 64'd0);
        chk("R7 clock output enables", {62'd0, bclk_oe, lrck_oe}, 64'd3);
        lrck_master = 1'b0;
        @(negedge clk);
        chk("R7 frame clock slave no drive", {63'd0, lrck_oe}, 64'd0);
        lrck_master = 1'b1; sdo_en = 1'b1;

        // R6 polarity, R5 right-half level, observed while disabled
        en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 R5 normal clocks idle", {62'd0, bclk_o, lrck_o}, 64'd3);
        bclk_inv = 1'b1; lrck_inv = 1'b1;
        @(negedge clk);
        chk("R6 inverted clocks idle", {62'd0, bclk_o, lrck_o}, 64'd0);
        bclk_inv = 1'b0; lrck_inv = 1'b0;

        // R5 programmable period: per=19 gives 40 bit clocks per frame
        per = 8'd19;
        en = 1'b1;
        begin
            logic pl, pb;
            int rises, falls;
            rises = 0; falls = 0; pl = lrck_o; pb = bclk_o;
            while (falls < 2) begin
                @(negedge clk);
                if (!bclk_o && pb && falls == 1) rises++;
                if (pl && !lrck_o) falls++;
                pl = lrck_o; pb = bclk_o;
            end
            chk("R5 frame length in bit clocks", 64'(rises), 64'd40);
        end
        en = 1'b0; per = 8'd31;

        // R7 slave clocks driven from the pins, I2S framing
        stb_on = 1'b0;
        bclk_master = 1'b0; lrck_master = 1'b0;
        mode = 2'd1; data_off = 1'b1; tx_left = 16'h5AA5; tx_right = 16'hC33C;
        tx_valid = 1'b1;
        repeat (4) @(negedge clk);
        en = 1'b1;
        for (int f = 0; f < 4; f++) begin
            for (int p = 0; p < 2 * H; p++) begin
                bclk_i = 1'b0;
                lrck_i = (p >= H);
                repeat (4) @(negedge clk);
                bclk_i = 1'b1;
                repeat (4) @(negedge clk);
            end
        end
        repeat (6) @(negedge clk);
        chk("R7 slave loopback pair", {32'd0, rx_left, rx_right}, {32'd0, 16'h5AA5, 16'hC33C});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule